// File: doc/BRIEF.md
# Periodic Real-Time Clock Register File

This block keeps calendar time in binary and lets software reach it through two ports. Software first writes a register index to the index port. Each later data read or data write then targets the register that index selects. The index stays in place until software writes a new one, so several data accesses can follow one index write.

A periodic strobe from a fixed-rate source drives the block. Every strobe produces a one-cycle interrupt pulse and advances a tick counter. After every 1024 strobes the seconds field steps once, wrapping from 59 to 0.

Minutes, hours, weekday, day of month, month and year do not roll over on their own. Software sets them. The alarm slots read as zero, and the status bytes return fixed mode values.

Top module: `rtc_regfile`

## Requirements
- R1: After reset, irq_o and err_o are 0, seconds and minutes read 0, month reads 1 and year reads 0.
- R2: A cycle with tick_i high makes irq_o high in the next cycle. irq_o is low in every cycle that does not follow a tick.
- R3: Seconds advance on exactly the 1024th tick after the tick counter was last at zero, not earlier.
- R4: Seconds advance as (seconds + 1) modulo 60, so 59 steps to 0.
- R5: A write on the index port selects the register for all following data accesses until the index is written again.
- R6: Index 0x0A (status A) reads as {uip_i, 7'h26}.
- R7: Index 0x0B (status B) reads 0x46, and index 0x0C (status C) reads 0x00.
- R8: Alarm indices 0x01, 0x03 and 0x05 always read 0x00, and writes to them change no register.
- R9: Month (index 0x08) is written and read in the range 1 to 12, and year (index 0x09) reads back the value written. The stored month is the written value minus 1, and the stored year is the written value plus 52.
- R10: Seconds 0x00, minutes 0x02, hours 0x04, weekday 0x06 and day of month 0x07 are writable and read back the value written.
- R11: A data read or write at index 0x0D or above sets err_o, which stays set until reset. Such a read returns 0x00.
- R12: rdata_o shows the selected register in the cycle after data_rd_i and holds it until the next read. A write takes effect at the clock edge where it is presented, so a read in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Periodic interrupt strobe, one cycle per tick |
| uip_i | input | 1 | Update-in-progress flag shown in status A bit 7 |
| addr_wr_i | input | 1 | Write wdata_i to the index register |
| data_wr_i | input | 1 | Write wdata_i to the selected register |
| data_rd_i | input | 1 | Read the selected register into rdata_o |
| wdata_i | input | 8 | Write data for the index and data ports |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Periodic interrupt pulse |
| err_o | output | 1 | Sticky flag for an access to an undefined index |

## Verification
Each result has its own due cycle. Read data, the interrupt pulse and the error flag all appear one clock edge after the strobe that causes them. A write is visible to a read issued in the following cycle.

The bench drives inputs on the falling edge. Its monitor records which rising edge carried a read strobe and compares the queued expected byte at the falling edge that comes next. The interrupt and error checks sample at the first falling edge after the tick or the faulty access. Before it tests the seconds boundary, the bench tracks the tick count modulo 1024 itself, so the 1023rd and 1024th ticks are each checked against a read taken right after them.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [7:0] {
        IX_SEC      = 8'h00,
        IX_SEC_ALM  = 8'h01,
        IX_MIN      = 8'h02,
        IX_MIN_ALM  = 8'h03,
        IX_HOUR     = 8'h04,
        IX_HOUR_ALM = 8'h05,
        IX_WDAY     = 8'h06,
        IX_MDAY     = 8'h07,
        IX_MON      = 8'h08,
        IX_YEAR     = 8'h09,
        IX_STAT_A   = 8'h0A,
        IX_STAT_B   = 8'h0B,
        IX_STAT_C   = 8'h0C,
        IX_STAT_D   = 8'h0D
    } reg_ix_e;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t wday;
        byte_t mday;
        byte_t mon;   // zero-based
        byte_t year;  // biased
    } clock_t;

    localparam byte_t STAT_A_LOW = 8'h26;
    localparam byte_t STAT_B_VAL = 8'h46;
    localparam byte_t YEAR_BIAS  = 8'd52;

    function automatic byte_t sec_step(byte_t s);
        logic [8:0] w;
        w = {1'b0, s} + 9'd1;
        return byte_t'(w % 9'd60);
    endfunction

    function automatic logic ix_is_bad(byte_t ix);
        return ix >= 8'h0D;
    endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int CNT_W = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic irq_o,
    output logic adv_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq_o <= 1'b0;
        end else begin
            irq_o <= tick_i;
            if (tick_i) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign adv_o = tick_i && (cnt_q == CNT_MAX);

    p_irq_follows_r2: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> irq_o);
    p_irq_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> !irq_o);
    p_cnt_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick_i && cnt_q == CNT_MAX) |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
    import rtc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv_i,
    input  logic   wr_en_i,
    input  byte_t  idx_i,
    input  byte_t  wdata_i,
    output clock_t now_o
);
    clock_t now_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q      <= '0;
            now_q.year <= YEAR_BIAS;
        end else begin
            if (adv_i) now_q.sec <= sec_step(now_q.sec);
            if (wr_en_i) begin
                case (idx_i)
                    IX_SEC:  now_q.sec  <= wdata_i;
                    IX_MIN:  now_q.min  <= wdata_i;
                    IX_HOUR: now_q.hour <= wdata_i;
                    IX_WDAY: now_q.wday <= wdata_i;
                    IX_MDAY: now_q.mday <= wdata_i;
                    IX_MON:  now_q.mon  <= wdata_i - 8'd1;
                    IX_YEAR: now_q.year <= wdata_i + YEAR_BIAS;
                    default: ;
                endcase
            end
        end
    end

    assign now_o = now_q;

    p_sec_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (adv_i && now_q.sec == 8'd59 && !(wr_en_i && idx_i == IX_SEC))
        |=> (now_q.sec == 8'd0));
    p_sec_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!adv_i && !wr_en_i) |=> $stable(now_q));

endmodule

// File: rtl/rtc_read_port.sv
module rtc_read_port
    import rtc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rd_i,
    input  byte_t  idx_i,
    input  clock_t now_i,
    input  logic   uip_i,
    output byte_t  rdata_o
);
    byte_t sel;

    always_comb begin
        case (idx_i)
            IX_SEC:    sel = now_i.sec;
            IX_MIN:    sel = now_i.min;
            IX_HOUR:   sel = now_i.hour;
            IX_WDAY:   sel = now_i.wday;
            IX_MDAY:   sel = now_i.mday;
            IX_MON:    sel = now_i.mon + 8'd1;
            IX_YEAR:   sel = now_i.year - YEAR_BIAS;
            IX_STAT_A: sel = {uip_i, STAT_A_LOW[6:0]};
            IX_STAT_B: sel = STAT_B_VAL;
            default:   sel = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       rdata_o <= 8'h00;
        else if (rd_i) rdata_o <= sel;
    end

    p_alarm_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_i && (idx_i == IX_SEC_ALM || idx_i == IX_MIN_ALM || idx_i == IX_HOUR_ALM))
        |=> (rdata_o == 8'h00));
    p_stat_b_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_i && idx_i == IX_STAT_B) |=> (rdata_o == 8'h46));
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !rd_i |=> $stable(rdata_o));

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int TICK_BITS = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       uip_i,
    input  logic       addr_wr_i,
    input  logic       data_wr_i,
    input  logic       data_rd_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       irq_o,
    output logic       err_o
);
    byte_t  idx_q;
    logic   err_q;
    logic   adv;
    clock_t now;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= 8'h00;
            err_q <= 1'b0;
        end else begin
            if (addr_wr_i) idx_q <= wdata_i;
            if ((data_wr_i || data_rd_i) && ix_is_bad(idx_q)) err_q <= 1'b1;
        end
    end

    assign err_o = err_q;

    rtc_tick_div #(.CNT_W(TICK_BITS)) u_div (
        .clk(clk), .rst(rst), .tick_i(tick_i), .irq_o(irq_o), .adv_o(adv)
    );

    rtc_time_regs u_time (
        .clk(clk), .rst(rst), .adv_i(adv), .wr_en_i(data_wr_i),
        .idx_i(idx_q), .wdata_i(wdata_i), .now_o(now)
    );

    rtc_read_port u_rd (
        .clk(clk), .rst(rst), .rd_i(data_rd_i), .idx_i(idx_q),
        .now_i(now), .uip_i(uip_i), .rdata_o(rdata_o)
    );

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);
    p_err_set_r11: assert property (@(posedge clk) disable iff (rst)
        ((data_rd_i || data_wr_i) && idx_q >= 8'h0D) |=> err_o);

endmodule

// File: tb/test_rtc_regfile.sv
`timescale 1ns/1ps
module test_rtc_regfile;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0, uip_i = 1'b0;
    logic       addr_wr_i = 1'b0, data_wr_i = 1'b0, data_rd_i = 1'b0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic       irq_o, err_o;

    int n_chk = 0, n_bad = 0;
    int tick_cnt = 0;
    logic rd_seen = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    rtc_regfile i_rtc_regfile (
        .clk(clk), .rst(rst), .tick_i(tick_i), .uip_i(uip_i),
        .addr_wr_i(addr_wr_i), .data_wr_i(data_wr_i), .data_rd_i(data_rd_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .err_o(err_o)
    );

    // monitor: compare read data at the falling edge after a read edge
    always @(posedge clk) rd_seen <= data_rd_i;
    always @(negedge clk) begin
        if (rd_seen) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (rdata_o !== e) begin
                n_bad++;
                $display("FAIL %s: rdata actual %02h expected %02h", t, rdata_o, e);
            end
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string t);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", t, act, exp);
        end
    endtask

    task automatic set_ix(input logic [7:0] ix);
        addr_wr_i = 1'b1; wdata_i = ix;
        @(negedge clk);
        addr_wr_i = 1'b0;
    endtask

    task automatic wr_cur(input logic [7:0] v);
        data_wr_i = 1'b1; wdata_i = v;
        @(negedge clk);
        data_wr_i = 1'b0;
    endtask

    task automatic wr(input logic [7:0] ix, input logic [7:0] v);
        set_ix(ix);
        wr_cur(v);
    endtask

    task automatic rd_cur(input logic [7:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        data_rd_i = 1'b1;
        @(negedge clk);
        data_rd_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] ix, input logic [7:0] e, input string t);
        set_ix(ix);
        rd_cur(e, t);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            @(negedge clk);
        end
        tick_i = 1'b0;
        tick_cnt = (tick_cnt + n) % 1024;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({7'd0, irq_o}, 8'd0, "R1 irq");
        chk({7'd0, err_o}, 8'd0, "R1 err");
        rd(8'h00, 8'd0, "R1 sec");
        rd(8'h02, 8'd0, "R1 min");
        rd(8'h08, 8'd1, "R1 month");
        rd(8'h09, 8'd0, "R1 year");
        // R6 status A
        rd(8'h0A, 8'h26, "R6 statA uip0");
        uip_i = 1'b1;
        rd(8'h0A, 8'hA6, "R6 statA uip1");
        uip_i = 1'b0;
        // R7 status B / C
        rd(8'h0B, 8'h46, "R7 statB");
        rd(8'h0C, 8'h00, "R7 statC");
        // R10 time fields
        wr(8'h00, 8'd12); wr(8'h02, 8'd34); wr(8'h04, 8'd21);
        wr(8'h06, 8'd3);  wr(8'h07, 8'd28);
        rd(8'h00, 8'd12, "R10 sec");
        rd(8'h02, 8'd34, "R10 min");
        rd(8'h04, 8'd21, "R10 hour");
        rd(8'h06, 8'd3,  "R10 wday");
        rd(8'h07, 8'd28, "R10 mday");
        // R9 month and year
        wr(8'h08, 8'd12); rd(8'h08, 8'd12, "R9 month 12");
        wr(8'h08, 8'd1);  rd(8'h08, 8'd1,  "R9 month 1");
        wr(8'h09, 8'd25); rd(8'h09, 8'd25, "R9 year");
        // R8 alarms read zero, writes ignored
        wr(8'h01, 8'h55); wr(8'h03, 8'h66); wr(8'h05, 8'h77);
        rd(8'h01, 8'h00, "R8 sec alarm");
        rd(8'h03, 8'h00, "R8 min alarm");
        rd(8'h05, 8'h00, "R8 hour alarm");
        rd(8'h00, 8'd12, "R8 sec untouched");
        rd(8'h02, 8'd34, "R8 min untouched");
        rd(8'h04, 8'd21, "R8 hour untouched");
        chk({7'd0, err_o}, 8'd0, "R11 no err yet");
        // R5 index persists
        set_ix(8'h02);
        rd_cur(8'd34, "R5 first");
        rd_cur(8'd34, "R5 second");
        wr_cur(8'd40);
        rd_cur(8'd40, "R5 write via held index");
        // R12 same-cycle read sees old value
        set_ix(8'h00);
        exp_q.push_back(8'd12); tag_q.push_back("R12 read-during-write old");
        data_wr_i = 1'b1; data_rd_i = 1'b1; wdata_i = 8'd7;
        @(negedge clk);
        data_wr_i = 1'b0; data_rd_i = 1'b0;
        rd_cur(8'd7, "R12 next read new");
        // R2 interrupt pulse
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        tick_cnt = (tick_cnt + 1) % 1024;
        chk({7'd0, irq_o}, 8'd1, "R2 irq high");
        @(negedge clk);
        chk({7'd0, irq_o}, 8'd0, "R2 irq low");
        // R3 seconds boundary
        wr(8'h00, 8'd5);
        ticks((1023 - tick_cnt) % 1024);
        rd(8'h00, 8'd5, "R3 no step at 1023");
        ticks(1);
        rd(8'h00, 8'd6, "R3 step at 1024");
        // R4 modulo 60
        wr(8'h00, 8'd59);
        ticks(1024);
        rd(8'h00, 8'd0, "R4 59 wraps to 0");
        // R11 undefined index
        rd(8'h0D, 8'h00, "R11 statD reads zero");
        chk({7'd0, err_o}, 8'd1, "R11 err set");
        rd(8'h00, 8'd0, "R11 sec after err");
        chk({7'd0, err_o}, 8'd1, "R11 err sticky");
        rd(8'h20, 8'h00, "R11 high index zero");
        repeat (3) @(negedge clk);
        summary();
    end
endmodule